// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash bus and turns one request into a complete, correctly timed device operation. A client hands it either a single-byte program (target address plus data) or a whole-chip erase over a valid/ready handshake. The block then plays out the unlock write sequence the flash needs. Every write is a WE-controlled bus cycle whose low and high widths are set by parameters counted in clock cycles.

Once the last command write has gone out, the block releases the data bus and reads back repeatedly, with OE strobes, until bit 7 shows the expected value. For a program that value is bit 7 of the written byte. For an erase it is 1. It then raises a one-cycle completion pulse. A flag on that pulse tells the client whether the operation finished or whether the poll budget ran out first.

All bus strobes and the data-bus enable come straight from flops. The address and write data are chosen from registered state only, so no combinational glitch reaches the asynchronous flash pins.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, ce_n, oe_n and we_n are 1, dq_oe is 0, req_ready is 1 and done is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle until done pulses, req_ready is 0.
- R3: A program request produces exactly four write cycles, in this order: 8'hAA at 16'h5555, 8'h55 at 16'h2AAA, 8'hA0 at 16'h5555, and finally the request data at the request address.
- R4: An erase request (req_erase=1) produces exactly six write cycles, in this order: 8'hAA@16'h5555, 8'h55@16'h2AAA, 8'h80@16'h5555, 8'hAA@16'h5555, 8'h55@16'h2AAA, 8'h10@16'h5555.
- R5: Each write holds we_n low for exactly WE_LOW_CYC cycles. Between the rising edge of one write and the falling edge of the next, we_n stays high for at least WE_HIGH_CYC cycles. fl_addr and fl_dq_out do not change while we_n is low.
- R6: While we_n is low, oe_n is 1 and dq_oe is 1. While oe_n is low, dq_oe is 0.
- R7: dq_oe is already 0 in the cycle before each falling edge of oe_n. Each poll read holds oe_n low for ACC_CYC cycles, and fl_addr during a poll read is the request address.
- R8: A program completes at the first poll read whose bit 7 equals bit 7 of the written byte. done then pulses for one cycle with timeout 0.
- R9: An erase completes at the first poll read whose bit 7 is 1. done then pulses with timeout 0.
- R10: When POLL_MAX reads pass without completion, done pulses with timeout 1 and no further read is made.
- R11: ce_n is 0 from acceptance until done, and it is already 0 one cycle before every falling edge of we_n. ce_n is 1 in the cycle done pulses and while idle.
- R12: req_valid pulses that arrive while busy are ignored: the running operation's write cycles and addresses are unchanged, and no extra operation starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_erase | input | 1 | 1 = whole-chip erase, 0 = byte program |
| req_addr | input | 16 | Program target / poll address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Valid with done: poll budget exhausted |
| fl_addr | output | 16 | Flash address bus |
| fl_dq_out | output | 8 | Flash data driven during writes |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | 8 | Flash data read back |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench drives a behavioural flash model that logs every write cycle at the rising edge of we_n. On poll reads the model returns a configurable number of "busy" bytes before the true value. Programs are run with a data byte whose bit 7 is 0 and one whose bit 7 is 1, so that a design comparing against a fixed polarity is caught. An erase is run with a busy value of 8'h00, which shows that erase completion keys on a 1 and not on the written byte. Runs with an endless busy phase, one for a program and one for an erase, check that the read count stops at the budget and that the timeout flag is set. A run that fires a stray request mid-operation checks that the logged command stream is left unchanged.

// File: rtl/fp_pkg.sv
package fp_pkg;

    localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  UNLK_KEY_A  = 8'hAA;
    localparam logic [7:0]  UNLK_KEY_B  = 8'h55;
    localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
    localparam logic [7:0]  OP_ERASE    = 8'h80;
    localparam logic [7:0]  OP_ERASE_GO = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WLOW,
        ST_WHIGH,
        ST_PTURN,
        ST_PREAD,
        ST_PGAP
    } fp_state_e;

    typedef struct packed {
        fp_state_e   st;
        logic [2:0]  step;
        logic        erase;
        logic [15:0] tgt_a;
        logic [7:0]  tgt_d;
        logic        want7;
        logic        ce_n;
        logic        oe_n;
        logic        we_n;
        logic        dq_oe;
        logic        done;
        logic        tmo;
    } fp_ctl_t;

endpackage

// File: rtl/fp_cycle_timer.sv
module fp_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R5/R10: an expired counter stays expired until it is reloaded
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/fp_cmd_table.sv
module fp_cmd_table
    import fp_pkg::*;
(
    input  logic        erase,
    input  logic [2:0]  step,
    input  logic [15:0] tgt_addr,
    input  logic [7:0]  tgt_data,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        last
);
    // step 0/1 (and 3/4 of erase) are the shared two-write unlock pair
    always_comb begin
        wr_addr = UNLK_ADDR_A;
        wr_data = UNLK_KEY_A;
        if (erase) begin
            last = (step == 3'd5);
            case (step)
                3'd0, 3'd3: begin wr_addr = UNLK_ADDR_A; wr_data = UNLK_KEY_A;  end
                3'd1, 3'd4: begin wr_addr = UNLK_ADDR_B; wr_data = UNLK_KEY_B;  end
                3'd2:       begin wr_addr = UNLK_ADDR_A; wr_data = OP_ERASE;    end
                default:    begin wr_addr = UNLK_ADDR_A; wr_data = OP_ERASE_GO; end
            endcase
        end else begin
            last = (step == 3'd3);
            case (step)
                3'd0:    begin wr_addr = UNLK_ADDR_A; wr_data = UNLK_KEY_A; end
                3'd1:    begin wr_addr = UNLK_ADDR_B; wr_data = UNLK_KEY_B; end
                3'd2:    begin wr_addr = UNLK_ADDR_A; wr_data = OP_PROGRAM; end
                default: begin wr_addr = tgt_addr;    wr_data = tgt_data;   end
            endcase
        end
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fp_pkg::*;
#(
    parameter int WE_LOW_CYC  = 25,
    parameter int WE_HIGH_CYC = 25,
    parameter int ACC_CYC     = 10,
    parameter int GAP_CYC     = 2,
    parameter int POLL_MAX    = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_erase,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_data,
    output logic        done,
    output logic        timeout,
    output logic [15:0] fl_addr,
    output logic [7:0]  fl_dq_out,
    output logic        fl_dq_oe,
    input  logic [7:0]  fl_dq_in,
    output logic        fl_ce_n,
    output logic        fl_oe_n,
    output logic        fl_we_n
);
    localparam int MAX_A = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
    localparam int MAX_B = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
    localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PW = $clog2(MAX_PH + 1);
    localparam int BW = $clog2(POLL_MAX + 1);

    fp_ctl_t q, d;

    logic          ph_load, ph_zero;
    logic [PW-1:0] ph_val;
    logic          bud_load, bud_dec, bud_zero;
    logic [15:0]   tbl_addr;
    logic [7:0]    tbl_data;
    logic          tbl_last;
    logic          rd_unused;

    assign rd_unused = ^fl_dq_in[6:0];

    fp_cmd_table u_tbl (
        .erase    (q.erase),
        .step     (q.step),
        .tgt_addr (q.tgt_a),
        .tgt_data (q.tgt_d),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .last     (tbl_last)
    );

    fp_cycle_timer #(.W(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .dec      (1'b1),
        .zero     (ph_zero)
    );

    fp_cycle_timer #(.W(BW)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bud_load),
        .load_val (BW'(POLL_MAX - 1)),
        .dec      (bud_dec),
        .zero     (bud_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.tmo    = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        bud_load = 1'b0;
        bud_dec  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.erase = req_erase;
                    d.tgt_a = req_addr;
                    d.tgt_d = req_data;
                    d.want7 = req_erase ? 1'b1 : req_data[7];
                    d.step  = 3'd0;
                    d.st    = ST_WSET;
                end
            end
            ST_WSET: begin
                d.st    = ST_WLOW;
                ph_load = 1'b1;
                ph_val  = PW'(WE_LOW_CYC - 1);
            end
            ST_WLOW: begin
                if (ph_zero) begin
                    d.st    = ST_WHIGH;
                    ph_load = 1'b1;
                    ph_val  = PW'(WE_HIGH_CYC - 1);
                end
            end
            ST_WHIGH: begin
                if (ph_zero) begin
                    if (tbl_last) begin
                        d.st = ST_PTURN;
                    end else begin
                        d.step = q.step + 3'd1;
                        d.st   = ST_WSET;
                    end
                end
            end
            ST_PTURN: begin
                d.st     = ST_PREAD;
                ph_load  = 1'b1;
                ph_val   = PW'(ACC_CYC - 1);
                bud_load = 1'b1;
            end
            ST_PREAD: begin
                if (ph_zero) begin
                    if (fl_dq_in[7] == q.want7) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else if (bud_zero) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.tmo  = 1'b1;
                    end else begin
                        bud_dec = 1'b1;
                        d.st    = ST_PGAP;
                        ph_load = 1'b1;
                        ph_val  = PW'(GAP_CYC - 1);
                    end
                end
            end
            ST_PGAP: begin
                if (ph_zero) begin
                    d.st    = ST_PREAD;
                    ph_load = 1'b1;
                    ph_val  = PW'(ACC_CYC - 1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // pin strobes follow the next state so each is a plain flop output
        d.ce_n  = (d.st == ST_IDLE);
        d.we_n  = (d.st != ST_WLOW);
        d.oe_n  = (d.st != ST_PREAD);
        d.dq_oe = (d.st == ST_WSET) || (d.st == ST_WLOW) || (d.st == ST_WHIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ce_n  <= 1'b1;
            q.oe_n  <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign timeout   = q.tmo;
    assign fl_ce_n   = q.ce_n;
    assign fl_oe_n   = q.oe_n;
    assign fl_we_n   = q.we_n;
    assign fl_dq_oe  = q.dq_oe;
    assign fl_addr   = q.dq_oe ? tbl_addr : q.tgt_a;
    assign fl_dq_out = tbl_data;

    p_oe_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && fl_dq_oe));

    p_no_bus_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

    p_release_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_oe_n) |-> !$past(fl_dq_oe));

    p_hold_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    p_ce_before_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> (!fl_ce_n && !$past(fl_ce_n)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && fl_ce_n));

    p_tmo_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;
    localparam int WE_L = 4;
    localparam int WE_H = 3;
    localparam int ACC  = 3;
    localparam int GAP  = 2;
    localparam int PMAX = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready, done, timeout;
    logic [15:0] fl_addr;
    logic [7:0]  fl_dq_out, fl_dq_in;
    logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    always #4 clk = ~clk;

    flash_prog_ctrl #(
        .WE_LOW_CYC(WE_L), .WE_HIGH_CYC(WE_H), .ACC_CYC(ACC),
        .GAP_CYC(GAP), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
        .done(done), .timeout(timeout), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---- flash model ----
    logic [15:0] wa [0:7];
    logic [7:0]  wd [0:7];
    int          wn = 0;
    int          reads = 0;
    int          busy_reads = 0;
    logic [7:0]  busy_byte = 8'h00;
    logic [7:0]  final_byte = 8'hFF;
    logic [15:0] rd_addr_seen = '0;

    always_comb begin
        if (!fl_oe_n && !fl_ce_n)
            fl_dq_in = (reads < busy_reads) ? busy_byte : final_byte;
        else
            fl_dq_in = 8'h00;
    end

    logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
    int          lowcnt = 0, highcnt = 100, oecnt = 0;
    logic [15:0] fall_a = '0;
    logic [7:0]  fall_d = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !fl_we_n) begin
                chk(highcnt >= WE_H, "R5 we high width", highcnt, WE_H);
                chk(!fl_ce_n, "R11 ce low at we fall", fl_ce_n, 0);
                lowcnt = 1; fall_a = fl_addr; fall_d = fl_dq_out;
            end else if (!fl_we_n) begin
                lowcnt++;
            end
            if (!prev_we && fl_we_n) begin
                chk(lowcnt == WE_L, "R5 we low width", lowcnt, WE_L);
                chk(fall_a == fl_addr && fall_d == fl_dq_out, "R5 addr/data stable", fl_addr, fall_a);
                if (wn < 8) begin wa[wn] = fall_a; wd[wn] = fall_d; end
                wn++;
                highcnt = 1;
            end else if (fl_we_n) begin
                highcnt++;
            end
            if (!fl_we_n)
                chk(fl_oe_n && fl_dq_oe, "R6 oe high while writing", {fl_oe_n, fl_dq_oe}, 2'b11);
            if (prev_oe && !fl_oe_n) begin
                chk(!prev_dqoe && !fl_dq_oe, "R7 bus released before read", prev_dqoe, 0);
                oecnt = 1; rd_addr_seen = fl_addr;
            end else if (!fl_oe_n) begin
                oecnt++;
            end
            if (!prev_oe && fl_oe_n) begin
                chk(oecnt == ACC, "R7 read strobe width", oecnt, ACC);
                reads++;
            end
        end
        prev_we = fl_we_n; prev_oe = fl_oe_n; prev_dqoe = fl_dq_oe;
    end

    function automatic logic [15:0] exp_a(input bit er, input int i, input logic [15:0] t);
        logic [15:0] ea [0:5];
        ea = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
        if (!er && i == 3) return t;
        return ea[i];
    endfunction

    function automatic logic [7:0] exp_d(input bit er, input int i, input logic [7:0] v);
        logic [7:0] pd [0:2];
        logic [7:0] ed [0:5];
        pd = '{8'hAA, 8'h55, 8'hA0};
        ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        if (er) return ed[i];
        if (i == 3) return v;
        return pd[i];
    endfunction

    task automatic run_op(input bit er, input logic [15:0] a, input logic [7:0] v,
                          input int busy, input bit exp_tmo, input int exp_reads,
                          input bit intrude, input string tag);
        bit seen = 0;
        bit ce_bad = 0;
        bit rdy_bad = 0;
        int nwr = er ? 6 : 4;
        wn = 0; reads = 0; busy_reads = busy;
        if (er) begin busy_byte = 8'h00; final_byte = 8'hFF; end
        else    begin busy_byte = v ^ 8'h80; final_byte = v; end
        @(negedge clk);
        chk(req_ready, {tag, " R2 ready before"}, req_ready, 1);
        req_valid = 1; req_erase = er; req_addr = a; req_data = v;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, {tag, " R2 busy after accept"}, req_ready, 0);
        for (int c = 0; c < 3000; c++) begin
            if (intrude && c == 5) begin
                req_valid = 1; req_erase = ~er; req_addr = a ^ 16'h0F0F; req_data = ~v;
            end
            if (intrude && c == 15) req_valid = 0;
            if (done) begin seen = 1; break; end
            if (fl_ce_n) ce_bad = 1;
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
        end
        req_valid = 0;
        chk(seen, {tag, " R8 done seen"}, seen, 1);
        chk(timeout == exp_tmo, {tag, " R10 timeout flag"}, timeout, exp_tmo);
        chk(fl_ce_n, {tag, " R11 ce high at done"}, fl_ce_n, 1);
        chk(!ce_bad, {tag, " R11 ce held low while busy"}, ce_bad, 0);
        chk(!rdy_bad, {tag, " R2 ready low while busy"}, rdy_bad, 0);
        @(negedge clk);
        chk(!done, {tag, " R8 done is one pulse"}, done, 0);
        chk(reads == exp_reads, {tag, " R8/R9/R10 poll read count"}, reads, exp_reads);
        chk(rd_addr_seen == a, {tag, " R7 poll address"}, rd_addr_seen, a);
        chk(wn == nwr, {tag, er ? " R4 write count" : " R3 write count"}, wn, nwr);
        for (int i = 0; i < nwr && i < wn; i++) begin
            chk(wa[i] == exp_a(er, i, a) && wd[i] == exp_d(er, i, v),
                {tag, er ? " R4 write cycle" : " R3 write cycle"},
                {wa[i], wd[i]}, {exp_a(er, i, a), exp_d(er, i, v)});
        end
        repeat (20) @(negedge clk);
        chk(wn == nwr && req_ready && fl_ce_n, {tag, " R12 nothing started after"}, wn, nwr);
    endtask

    task automatic t_reset;
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        chk(!fl_dq_oe, "R1 bus released", fl_dq_oe, 0);
        chk(req_ready && !done, "R1 ready, no done", {req_ready, done}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        run_op(0, 16'h1234, 8'h5A, 3,    0, 4,    0, "prog bit7=0");
        run_op(0, 16'hBEEF, 8'hC3, 0,    0, 1,    0, "prog bit7=1");
        run_op(1, 16'h0000, 8'h00, 2,    0, 3,    0, "erase R9");
        run_op(0, 16'h4001, 8'h0F, 1000, 1, PMAX, 0, "prog timeout R10");
        run_op(1, 16'h7FFF, 8'h00, 1000, 1, PMAX, 0, "erase timeout R10");
        run_op(0, 16'h2222, 8'h81, 2,    0, 3,    1, "intrude R12");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule